// File: doc/BRIEF.md
# Short-Term Flicker Severity Evaluator

This block is the statistical back end of a flickermeter. It receives a stream of non-negative fixed-point instantaneous flicker samples and sorts each one into a histogram class. When a strobe marks the end of an observation interval, it extracts fifteen exceedance percentiles from that histogram. The interval is typically 10 minutes and may be set anywhere from 1 to 15 minutes by the spacing of the strobes. From the percentiles it forms a weighted sum of smoothed percentile groups and takes its square root. The result is the short-term severity.

The block keeps the last twelve short-term results and derives a long-term severity from them as a cubic mean. The histogram is double-buffered. Samples that arrive while one interval is being evaluated are counted into the other bank, so no sample is lost at an interval boundary.

Each result is presented on a held output word together with a one-cycle valid pulse. Both severities are unsigned values with 8 fraction bits.

Top module: `flicker_severity`

## Requirements
- R1: A valid sample of value v is counted in histogram class min(v, NCLS-1). With the default NCLS = 64, every value of 63 or more lands in class 63. A class index is also the percentile level reported for that class.
- R2: Percentiles are computed for fifteen exceedance levels. Expressed in tenths of a percent, they are, in index order 0..14: 1, 7, 10, 15, 22, 30, 40, 60, 80, 100, 130, 170, 300, 500, 800. Level j takes the highest class k such that 1000·(samples in classes ≥ k) ≥ t_j·(samples in the interval). If the interval holds no samples, every level is 0.
- R3: The short-term value is pst = floor(sqrt(S)), where S = 2058·P[0] + 1147·(P[1]+P[2]+P[3]) + 1435·(P[4]+P[5]+P[6]) + 3670·(P[7]+…+P[11]) + 1748·(P[12]+P[13]+P[14]). The weights are 16-bit fractions that already include the 1/3 and 1/5 group means, so pst carries 8 fraction bits. The `pst_valid` signal pulses for exactly one cycle as `pst` takes the new value.
- R4: The block accepts an interval-end strobe while it is idle. An accepted strobe closes the interval, and a sample presented in the same cycle as the strobe belongs to the closing interval. From the next cycle on, samples go into the other histogram bank, which has just been emptied. This includes samples that arrive during the evaluation.
- R5: Evaluation keeps the block busy for NCLS+33 cycles after an accepted strobe. A strobe raised during that time is ignored: it neither closes an interval nor discards samples.
- R6: After each short-term result, plt = floor(cbrt(floor(C/12))), where C is the sum of the cubes of the last 12 pst values. The `plt_valid` signal pulses 16 cycles after `pst_valid`, and only once at least 12 short-term results exist. The two valid pulses never coincide.
- R7: After reset, `pst` and `plt` are 0, no valid pulse occurs, both histogram banks are empty and no short-term history is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp | input | DW | Instantaneous flicker sample |
| ival_end | input | 1 | End of observation interval |
| pst | output | 16 | Short-term severity, 8 fraction bits |
| pst_valid | output | 1 | One-cycle pulse on new pst |
| plt | output | 16 | Long-term severity, 8 fraction bits |
| plt_valid | output | 1 | One-cycle pulse on new plt |

## Verification
The embedded assertions check several properties on every cycle:
- the percentile levels are ordered once the scan completes;
- each short-term and long-term result is the exact floor root of the internal sum it was derived from;
- a freshly activated bank is empty;
- the two valid pulses never coincide.

Other behaviours only the bench scenarios can show:
- the percentile values themselves, including those of a single spike, a saturated interval and an empty interval;
- that a sample given with the strobe counts in the closing interval;
- that samples taken during an evaluation and after an ignored strobe land in the next interval;
- the onset of the long-term output after twelve intervals.

// File: rtl/flicker_severity.sv
module flicker_severity #(
  parameter int DW   = 8,
  parameter int NCLS = 64,
  parameter int CW   = 20,
  parameter int NLT  = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp,
  input  logic          ival_end,
  output logic [15:0]   pst,
  output logic          pst_valid,
  output logic [15:0]   plt,
  output logic          plt_valid
);
  localparam int CLW = $clog2(NCLS);
  localparam int CTW = (CLW > 4) ? CLW : 4;
  localparam int LTW = $clog2(NLT + 1);
  localparam int NP  = 15;
  localparam int unsigned PM [NP] = '{1, 7, 10, 15, 22, 30, 40, 60, 80, 100, 130, 170, 300, 500, 800};
  localparam logic [CLW-1:0] TOPC = CLW'(NCLS - 1);

  typedef enum logic [2:0] {S_IDLE, S_SCAN, S_SUM, S_SQRT, S_CBRT} st_t;
  st_t st;

  logic [CW-1:0]  hist [2][NCLS];
  logic [CW-1:0]  tot  [2];
  logic           act, eb;
  logic [CTW-1:0] cnt;
  logic [CW-1:0]  cum;
  logic [CLW-1:0] p [NP];
  logic [NP-1:0]  found, hit;
  logic [31:0]    acc;
  logic [15:0]    root;
  logic [47:0]    ring [NLT];
  logic [47:0]    lsum;
  logic [LTW-1:0] wp, nfill;

  wire            take  = ival_end && (st == S_IDLE);
  wire [CLW-1:0]  cls   = (32'(smp) > NCLS - 1) ? TOPC : CLW'(smp);
  wire [CW-1:0]   cum_n = cum + hist[eb][cnt[CLW-1:0]];

  for (genvar j = 0; j < NP; j++) begin : g_hit
    assign hit[j] = !found[j] && (cum_n != '0) &&
                    (48'(cum_n) * 48'd1000 >= 48'(PM[j]) * 48'(tot[eb]));
  end

  wire [31:0] wsum = 32'd2058 * 32'(p[0])
                   + 32'd1147 * (32'(p[1]) + 32'(p[2]) + 32'(p[3]))
                   + 32'd1435 * (32'(p[4]) + 32'(p[5]) + 32'(p[6]))
                   + 32'd3670 * (32'(p[7]) + 32'(p[8]) + 32'(p[9]) + 32'(p[10]) + 32'(p[11]))
                   + 32'd1748 * (32'(p[12]) + 32'(p[13]) + 32'(p[14]));

  wire [15:0] trial  = root | (16'd1 << cnt[3:0]);
  wire [47:0] trial3 = 48'(trial) * 48'(trial) * 48'(trial);
  wire [15:0] sq_n   = (32'(trial) * 32'(trial) <= acc) ? trial : root;
  wire [15:0] cb_n   = (trial3 <= lsum / 48'(NLT)) ? trial : root;
  wire [47:0] cube_n = 48'(sq_n) * 48'(sq_n) * 48'(sq_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++) begin
        tot[b] <= '0;
        for (int k = 0; k < NCLS; k++) hist[b][k] <= '0;
      end
    end else begin
      for (int b = 0; b < 2; b++) begin
        if (take && (b[0] == !act)) begin
          tot[b] <= '0;
          for (int k = 0; k < NCLS; k++) hist[b][k] <= '0;
        end else if (smp_valid && (b[0] == act)) begin
          tot[b]       <= tot[b] + 1'b1;
          hist[b][cls] <= hist[b][cls] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; act <= 1'b0; eb <= 1'b0; cnt <= '0; cum <= '0;
      found <= '0; acc <= '0; root <= '0; lsum <= '0; wp <= '0; nfill <= '0;
      pst <= '0; plt <= '0; pst_valid <= 1'b0; plt_valid <= 1'b0;
      for (int j = 0; j < NP; j++) p[j] <= '0;
      for (int i = 0; i < NLT; i++) ring[i] <= '0;
    end else begin
      pst_valid <= 1'b0;
      plt_valid <= 1'b0;
      case (st)
        S_IDLE: if (take) begin
          eb <= act; act <= !act; cum <= '0; found <= '0;
          cnt <= CTW'(NCLS - 1);
          for (int j = 0; j < NP; j++) p[j] <= '0;
          st <= S_SCAN;
        end
        S_SCAN: begin
          cum <= cum_n;
          for (int j = 0; j < NP; j++)
            if (hit[j]) begin p[j] <= cnt[CLW-1:0]; found[j] <= 1'b1; end
          if (cnt == '0) st <= S_SUM;
          else cnt <= cnt - 1'b1;
        end
        S_SUM: begin
          acc <= wsum; root <= '0; cnt <= CTW'(15); st <= S_SQRT;
        end
        S_SQRT: if (cnt == '0) begin
          pst <= sq_n; pst_valid <= 1'b1;
          ring[wp] <= cube_n;
          lsum <= lsum + cube_n - ring[wp];
          wp <= (wp == LTW'(NLT - 1)) ? '0 : wp + 1'b1;
          if (nfill != LTW'(NLT)) nfill <= nfill + 1'b1;
          root <= '0; cnt <= CTW'(15); st <= S_CBRT;
        end else begin
          root <= sq_n; cnt <= cnt - 1'b1;
        end
        S_CBRT: if (cnt == '0) begin
          plt <= cb_n; plt_valid <= (nfill == LTW'(NLT)); st <= S_IDLE;
        end else begin
          root <= cb_n; cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  for (genvar j = 0; j < NP - 1; j++) begin : g_ord
    AST_PCT_ORDER: assert property (@(posedge clk) disable iff (!rst_n) (st == S_SUM) |-> (p[j] >= p[j+1])); // R2
  end

  AST_PST_ROOT: assert property (@(posedge clk) disable iff (!rst_n) pst_valid |-> ((32'(pst) * 32'(pst) <= acc) && ((33'(pst) + 33'd1) * (33'(pst) + 33'd1) > 33'(acc)))); // R3
  AST_BANK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) $past(take) |-> (tot[act] == '0)); // R4
  AST_PLT_ROOT: assert property (@(posedge clk) disable iff (!rst_n) plt_valid |-> ((48'(plt) * 48'(plt) * 48'(plt) * 48'd12 <= lsum) && ((48'(plt) + 48'd1) * (48'(plt) + 48'd1) * (48'(plt) + 48'd1) * 48'd12 > lsum))); // R6
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(pst_valid && plt_valid)); // R6
endmodule

// File: tb/test_flicker_severity.sv
module test_flicker_severity;
  logic clk = 1'b0, rst_n = 1'b0, smp_valid = 1'b0, ival_end = 1'b0;
  logic [7:0] smp = '0;
  logic [15:0] pst, plt;
  logic pst_valid, plt_valid;

  flicker_severity i_flicker_severity (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp(smp), .ival_end(ival_end),
    .pst(pst), .pst_valid(pst_valid), .plt(plt), .plt_valid(plt_valid)
  );

  always #10 clk = ~clk;

  int nchk = 0, nerr = 0, nplt_seen = 0, nplt_exp = 0;
  bit done = 1'b0;
  int mh [64];
  int exp_pst [$];
  string exp_tag [$];
  int exp_plt [$];
  longint cubes [$];
  int tpm [15] = '{1, 7, 10, 15, 22, 30, 40, 60, 80, 100, 130, 170, 300, 500, 800};

  function automatic longint isqrt(longint s);
    longint r = 0;
    while ((r + 1) * (r + 1) <= s) r++;
    return r;
  endfunction

  function automatic longint icbrt(longint s);
    longint r = 0;
    while ((r + 1) * (r + 1) * (r + 1) <= s) r++;
    return r;
  endfunction

  task automatic push_expected(input string tag);
    longint tot = 0, cum = 0, s, sum = 0;
    int pv [15];
    bit fd [15];
    int v;
    for (int k = 0; k < 64; k++) tot += mh[k];
    for (int j = 0; j < 15; j++) begin pv[j] = 0; fd[j] = 0; end
    for (int k = 63; k >= 0; k--) begin
      cum += mh[k];
      for (int j = 0; j < 15; j++)
        if (!fd[j] && cum > 0 && cum * 1000 >= tpm[j] * tot) begin pv[j] = k; fd[j] = 1; end
    end
    s = 2058 * pv[0] + 1147 * (pv[1] + pv[2] + pv[3]) + 1435 * (pv[4] + pv[5] + pv[6])
      + 3670 * (pv[7] + pv[8] + pv[9] + pv[10] + pv[11]) + 1748 * (pv[12] + pv[13] + pv[14]);
    v = int'(isqrt(s));
    exp_pst.push_back(v);
    exp_tag.push_back(tag);
    cubes.push_back(longint'(v) * v * v);
    if (cubes.size() > 12) void'(cubes.pop_front());
    if (cubes.size() == 12) begin
      foreach (cubes[i]) sum += cubes[i];
      exp_plt.push_back(int'(icbrt(sum / 12)));
      nplt_exp++;
    end
    for (int k = 0; k < 64; k++) mh[k] = 0;
  endtask

  task automatic send(input int v);
    @(negedge clk);
    smp_valid = 1'b1; smp = 8'(v); ival_end = 1'b0;
    mh[v > 63 ? 63 : v]++;
  endtask

  task automatic strobe(input string tag, input bit with_smp, input int v, input bit counted);
    @(negedge clk);
    smp_valid = with_smp; smp = 8'(v); ival_end = 1'b1;
    if (with_smp) mh[v > 63 ? 63 : v]++;
    if (counted) push_expected(tag);
    @(negedge clk);
    smp_valid = 1'b0; ival_end = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    smp_valid = 1'b0; ival_end = 1'b0;
    repeat (150) @(negedge clk);
  endtask

  task automatic check(input string tag, input int got, input int expv);
    nchk++;
    if (got != expv) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", tag, got, expv);
    end
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (pst_valid) begin
        if (exp_pst.size() == 0) check("R3 unexpected pst_valid", 1, 0);
        else check({exp_tag.pop_front(), " pst"}, int'(pst), exp_pst.pop_front());
      end
      if (plt_valid) begin
        nplt_seen++;
        if (exp_plt.size() == 0) check("R6 unexpected plt_valid", 1, 0);
        else check("R6 plt", int'(plt), exp_plt.pop_front());
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin : driver
    for (int k = 0; k < 64; k++) mh[k] = 0;
    repeat (3) @(negedge clk);
    check("R7 pst", int'(pst), 0);
    check("R7 plt", int'(plt), 0);
    check("R7 valids", int'({pst_valid, plt_valid}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    strobe("R2 empty", 1'b0, 0, 1'b1); wait_idle();
    for (int i = 0; i < 50; i++) send(10);
    strobe("R3", 1'b0, 0, 1'b1); wait_idle();
    for (int i = 0; i < 100; i++) send(i);
    strobe("R1 ramp", 1'b0, 0, 1'b1); wait_idle();
    for (int i = 0; i < 30; i++) send(200);
    strobe("R1 sat", 1'b0, 0, 1'b1); wait_idle();
    for (int i = 0; i < 999; i++) send(2);
    send(40);
    strobe("R2 spike", 1'b0, 0, 1'b1); wait_idle();
    for (int i = 0; i < 20; i++) send(5);
    strobe("R4 same-cycle", 1'b1, 60, 1'b1);
    for (int i = 0; i < 15; i++) send(30);
    strobe("R5", 1'b0, 0, 1'b0);
    for (int i = 0; i < 15; i++) send(3);
    wait_idle();
    strobe("R4,R5 pingpong", 1'b0, 0, 1'b1); wait_idle();
    for (int m = 0; m < 7; m++) begin
      for (int i = 0; i < 60 + m * 10; i++) send((i * (m + 3)) % 90);
      strobe("R2 mix", 1'b0, 0, 1'b1); wait_idle();
    end

    repeat (200) @(negedge clk);
    check("R3 pending pst", exp_pst.size(), 0);
    check("R6 plt count", nplt_seen, nplt_exp);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule